// File: doc/BRIEF.md
# Predicated Five-Slot VLIW Issue Stage

This block is the issue stage of a very-long-instruction-word core. Each cycle it may take one decoded instruction word holding up to five operation slots. Every present slot names a guard register, an operand register and a target functional unit, and may be marked as a branch and as writing a result. The stage reads each guard from its register file and tests bit 0. An operation whose guard bit is 1 is dispatched to its unit. Any other present operation is squashed: it keeps its slot position but raises no strobe and no write-back enable.

Two registers are hardwired. Register 0 always reads 0 and therefore means "never". Register 1 always reads 1 and therefore means "always". Writes to either are dropped. The stage never checks whether the slots of a word clash, so two slots that name the same unit both go out. If an executing slot names a unit whose busy flag is set, the whole word is held until that unit frees up.

The stage also keeps the program counter, which counts issued words. A dispatched branch does not redirect fetch at once. The next three issued words always execute, and only after the third of them does the counter load the branch target. Stall cycles do not use up this window.

Top module: `vliw_issue_stage`

## Requirements
- R1: While rst_ni is low and after its release, pc_o equals RESET_PC (default 0), disp_valid_o and disp_wb_en_o are all zero, and word_ready_o is 1 when no unit is busy.
- R2: For an accepted word, a present slot whose guard register has bit 0 equal to 1 (for example the value 3) shows disp_valid_o high for that slot in the next cycle. A present slot whose guard value has bit 0 equal to 0 (for example 2), and any slot that is not present, shows disp_valid_o low. Slot s uses bit s of each per-slot vector and bits [s*W +: W] of each packed field.
- R3: Register 0 always reads as 0 and writes to it are dropped. A slot guarded by register 0 is never dispatched, and register 0 read as an operand gives 0.
- R4: Register 1 always reads as 1 and writes to it are dropped. A slot guarded by register 1 is always dispatched, and register 1 read as an operand gives 1.
- R5: While a present slot whose guard passes names a unit whose bit in unit_busy_i is set, word_ready_o is low. In that state no slot is dispatched and pc_o holds. The word issues on the first edge after the busy flag clears.
- R6: A squashed slot never causes a stall, even when its unit is busy.
- R7: Slots of one word are not checked against each other. Two executing slots that name the same unit are both dispatched in the same cycle, each with its own unit field.
- R8: pc_o advances by exactly 1 for each accepted word that is not the last word of a branch window. It holds in any cycle where no word is accepted.
- R9: A word that contains a dispatched branch slot starts a window of three further issued words, which execute normally at pc+1, pc+2 and pc+3. Once the third of them is accepted, pc_o becomes the captured branch_target_i. Stall cycles do not count toward the window. A squashed branch slot has no effect on pc_o.
- R10: disp_wb_en_o for a slot is high in the cycle after acceptance exactly when that slot is dispatched and its slot_wb_i bit was set.
- R11: disp_operand_o carries the value of the slot's operand register, and disp_unit_o carries its unit field, both as they were when the word was accepted. A write on the write port is visible to reads from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| word_valid_i | input | 1 | An instruction word is presented |
| word_ready_o | output | 1 | Word can issue this cycle (no busy unit is needed) |
| slot_present_i | input | NUM_SLOTS | Slot holds an operation |
| slot_branch_i | input | NUM_SLOTS | Slot is a branch |
| slot_wb_i | input | NUM_SLOTS | Slot writes a result |
| slot_unit_i | input | NUM_SLOTS*UW | Functional unit index per slot |
| slot_guard_i | input | NUM_SLOTS*RW | Guard register index per slot |
| slot_src_i | input | NUM_SLOTS*RW | Operand register index per slot |
| branch_target_i | input | PC_W | Target of the word's branch |
| unit_busy_i | input | NUM_UNITS | Busy flag per functional unit |
| wr_en_i | input | 1 | Register write enable |
| wr_addr_i | input | RW | Register write index |
| wr_data_i | input | XLEN | Register write data |
| disp_valid_o | output | NUM_SLOTS | Dispatch strobe per slot |
| disp_wb_en_o | output | NUM_SLOTS | Write-back enable per slot |
| disp_unit_o | output | NUM_SLOTS*UW | Unit field of the dispatched word |
| disp_operand_o | output | NUM_SLOTS*XLEN | Operand value per slot |
| pc_o | output | PC_W | Program counter (word index) |

## Verification
A corrupted register-file entry shows up the next time that entry is used. As a guard it flips a slot between dispatch and squash on disp_valid_o one cycle after issue. As an operand it appears on disp_operand_o in that same cycle. A wrong delay count is silent until the window closes: pc_o then loads the target one word early or late, or follows a squashed branch. The branch test therefore checks pc_o after every single issued word, including a stall placed inside the window. A wrong busy decode shows at once on word_ready_o, before any edge, so stall and no-stall cases both check it combinationally.

// File: rtl/vliw_issue_pkg.sv
package vliw_issue_pkg;
  localparam int unsigned REG_NEVER  = 0;
  localparam int unsigned REG_ALWAYS = 1;
  localparam int unsigned FIRST_RW_REG = 2;
endpackage

// File: rtl/vliw_guard_regfile.sv
module vliw_guard_regfile
  import vliw_issue_pkg::*;
#(
  parameter int unsigned NUM_REGS  = 128,
  parameter int unsigned XLEN      = 32,
  parameter int unsigned NUM_SLOTS = 5,
  localparam int unsigned RW = $clog2(NUM_REGS)
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      wr_en_i,
  input  logic [RW-1:0]             wr_addr_i,
  input  logic [XLEN-1:0]           wr_data_i,
  input  logic [NUM_SLOTS*RW-1:0]   gd_addr_i,
  output logic [NUM_SLOTS-1:0]      gd_bit_o,
  input  logic [NUM_SLOTS*RW-1:0]   op_addr_i,
  output logic [NUM_SLOTS*XLEN-1:0] op_data_o
);
  logic [XLEN-1:0] store_q [NUM_REGS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < int'(NUM_REGS); i++) store_q[i] <= '0;
    end else if (wr_en_i && (wr_addr_i >= RW'(FIRST_RW_REG))) begin
      store_q[wr_addr_i] <= wr_data_i;
    end
  end

  // guard ports: only bit 0 matters
  for (genvar p = 0; p < NUM_SLOTS; p++) begin : g_gd
    logic [RW-1:0] addr;
    logic          bit0;
    assign addr = gd_addr_i[p*RW +: RW];
    always_comb begin
      if (addr == RW'(REG_NEVER))       bit0 = 1'b0;
      else if (addr == RW'(REG_ALWAYS)) bit0 = 1'b1;
      else                              bit0 = store_q[addr][0];
    end
    assign gd_bit_o[p] = bit0;
  end

  for (genvar p = 0; p < NUM_SLOTS; p++) begin : g_op
    logic [RW-1:0]   addr;
    logic [XLEN-1:0] data;
    assign addr = op_addr_i[p*RW +: RW];
    always_comb begin
      if (addr == RW'(REG_NEVER))       data = '0;
      else if (addr == RW'(REG_ALWAYS)) data = XLEN'(1);
      else                              data = store_q[addr];
    end
    assign op_data_o[p*XLEN +: XLEN] = data;
  end
endmodule

// File: rtl/vliw_slot_eval.sv
module vliw_slot_eval #(
  parameter int unsigned NUM_UNITS = 8,
  localparam int unsigned UW = $clog2(NUM_UNITS)
) (
  input  logic                 present_i,
  input  logic                 guard_bit_i,
  input  logic [UW-1:0]        unit_i,
  input  logic [NUM_UNITS-1:0] unit_busy_i,
  output logic                 exec_o,
  output logic                 conflict_o
);
  logic unit_busy;

  always_comb begin
    unit_busy = 1'b0;
    if (int'(unit_i) < int'(NUM_UNITS)) unit_busy = unit_busy_i[unit_i];
  end

  assign exec_o     = present_i & guard_bit_i;
  // squashed slots never hold the word
  assign conflict_o = exec_o & unit_busy;
endmodule

// File: rtl/vliw_branch_seq.sv
module vliw_branch_seq #(
  parameter int unsigned PC_W        = 32,
  parameter int unsigned DELAY_SLOTS = 3,
  parameter int unsigned RESET_PC    = 0,
  localparam int unsigned DW = $clog2(DELAY_SLOTS + 1)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            issue_i,
  input  logic            taken_i,
  input  logic [PC_W-1:0] target_i,
  output logic [PC_W-1:0] pc_o
);
  logic [PC_W-1:0] pc_q, tgt_q;
  logic [DW-1:0]   left_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q   <= PC_W'(RESET_PC);
      tgt_q  <= '0;
      left_q <= '0;
    end else if (issue_i) begin
      if (left_q != '0) begin
        // branch inside an open window is undefined; ignored here
        left_q <= left_q - DW'(1);
        pc_q   <= (left_q == DW'(1)) ? tgt_q : pc_q + PC_W'(1);
      end else begin
        pc_q <= pc_q + PC_W'(1);
        if (taken_i) begin
          left_q <= DW'(DELAY_SLOTS);
          tgt_q  <= target_i;
        end
      end
    end
  end

  assign pc_o = pc_q;
endmodule

// File: rtl/vliw_issue_stage.sv
module vliw_issue_stage #(
  parameter int unsigned NUM_SLOTS   = 5,
  parameter int unsigned NUM_REGS    = 128,
  parameter int unsigned XLEN        = 32,
  parameter int unsigned NUM_UNITS   = 8,
  parameter int unsigned PC_W        = 32,
  parameter int unsigned DELAY_SLOTS = 3,
  parameter int unsigned RESET_PC    = 0,
  localparam int unsigned RW = $clog2(NUM_REGS),
  localparam int unsigned UW = $clog2(NUM_UNITS)
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      word_valid_i,
  output logic                      word_ready_o,
  input  logic [NUM_SLOTS-1:0]      slot_present_i,
  input  logic [NUM_SLOTS-1:0]      slot_branch_i,
  input  logic [NUM_SLOTS-1:0]      slot_wb_i,
  input  logic [NUM_SLOTS*UW-1:0]   slot_unit_i,
  input  logic [NUM_SLOTS*RW-1:0]   slot_guard_i,
  input  logic [NUM_SLOTS*RW-1:0]   slot_src_i,
  input  logic [PC_W-1:0]           branch_target_i,
  input  logic [NUM_UNITS-1:0]      unit_busy_i,
  input  logic                      wr_en_i,
  input  logic [RW-1:0]             wr_addr_i,
  input  logic [XLEN-1:0]           wr_data_i,
  output logic [NUM_SLOTS-1:0]      disp_valid_o,
  output logic [NUM_SLOTS-1:0]      disp_wb_en_o,
  output logic [NUM_SLOTS*UW-1:0]   disp_unit_o,
  output logic [NUM_SLOTS*XLEN-1:0] disp_operand_o,
  output logic [PC_W-1:0]           pc_o
);
  logic [NUM_SLOTS-1:0]      guard_bit, exec_vec, conflict_vec;
  logic [NUM_SLOTS*XLEN-1:0] operand;
  logic                      accept, taken;

  vliw_guard_regfile #(
    .NUM_REGS (NUM_REGS),
    .XLEN     (XLEN),
    .NUM_SLOTS(NUM_SLOTS)
  ) i_regfile (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (wr_en_i),
    .wr_addr_i(wr_addr_i),
    .wr_data_i(wr_data_i),
    .gd_addr_i(slot_guard_i),
    .gd_bit_o (guard_bit),
    .op_addr_i(slot_src_i),
    .op_data_o(operand)
  );

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    vliw_slot_eval #(.NUM_UNITS(NUM_UNITS)) i_eval (
      .present_i  (slot_present_i[s]),
      .guard_bit_i(guard_bit[s]),
      .unit_i     (slot_unit_i[s*UW +: UW]),
      .unit_busy_i(unit_busy_i),
      .exec_o     (exec_vec[s]),
      .conflict_o (conflict_vec[s])
    );
  end

  assign word_ready_o = ~|conflict_vec;
  assign accept       = word_valid_i & word_ready_o;
  assign taken        = |(exec_vec & slot_branch_i);

  vliw_branch_seq #(
    .PC_W       (PC_W),
    .DELAY_SLOTS(DELAY_SLOTS),
    .RESET_PC   (RESET_PC)
  ) i_branch (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .issue_i (accept),
    .taken_i (taken),
    .target_i(branch_target_i),
    .pc_o    (pc_o)
  );

  logic [NUM_SLOTS-1:0]      valid_q, wb_q;
  logic [NUM_SLOTS*UW-1:0]   unit_q;
  logic [NUM_SLOTS*XLEN-1:0] operand_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q   <= '0;
      wb_q      <= '0;
      unit_q    <= '0;
      operand_q <= '0;
    end else begin
      valid_q <= accept ? exec_vec : '0;
      wb_q    <= accept ? (exec_vec & slot_wb_i) : '0;
      if (accept) begin
        unit_q    <= slot_unit_i;
        operand_q <= operand;
      end
    end
  end

  assign disp_valid_o   = valid_q;
  assign disp_wb_en_o   = wb_q;
  assign disp_unit_o    = unit_q;
  assign disp_operand_o = operand_q;
endmodule

// File: rtl/vliw_issue_checker.sv
module vliw_issue_checker #(
  parameter int unsigned NUM_SLOTS = 5,
  parameter int unsigned RW        = 7,
  parameter int unsigned PC_W      = 32
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    word_valid_i,
  input logic                    word_ready_o,
  input logic [NUM_SLOTS-1:0]    slot_present_i,
  input logic [NUM_SLOTS*RW-1:0] slot_guard_i,
  input logic [NUM_SLOTS-1:0]    guard_bit_i,
  input logic [NUM_SLOTS-1:0]    disp_valid_o,
  input logic [NUM_SLOTS-1:0]    disp_wb_en_o,
  input logic [PC_W-1:0]         pc_o
);
  logic accept;
  assign accept = word_valid_i & word_ready_o;

  a_r5_stall_no_dispatch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !word_ready_o |=> disp_valid_o == '0);

  a_r8_pc_holds_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !accept |=> $stable(pc_o));

  a_r10_wb_needs_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (disp_wb_en_o & ~disp_valid_o) == '0);

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    a_r2_false_guard_squashed: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (accept && !guard_bit_i[s]) |=> !disp_valid_o[s]);

    a_r3_never_guard: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (accept && slot_guard_i[s*RW +: RW] == RW'(0)) |=> !disp_valid_o[s]);

    a_r4_always_guard: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (accept && slot_present_i[s] && slot_guard_i[s*RW +: RW] == RW'(1))
        |=> disp_valid_o[s]);
  end
endmodule

bind vliw_issue_stage vliw_issue_checker #(
  .NUM_SLOTS(NUM_SLOTS),
  .RW       (RW),
  .PC_W     (PC_W)
) i_checker (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .word_valid_i  (word_valid_i),
  .word_ready_o  (word_ready_o),
  .slot_present_i(slot_present_i),
  .slot_guard_i  (slot_guard_i),
  .guard_bit_i   (guard_bit),
  .disp_valid_o  (disp_valid_o),
  .disp_wb_en_o  (disp_wb_en_o),
  .pc_o          (pc_o)
);

// File: tb/test_vliw_issue_stage.sv
module test_vliw_issue_stage;
  localparam int S = 5, RW = 7, UW = 3, XLEN = 32, PC_W = 32, NU = 8;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic word_valid = 1'b0, word_ready;
  logic [S-1:0] slot_present = '0, slot_branch = '0, slot_wb = '0;
  logic [S*UW-1:0] slot_unit = '0;
  logic [S*RW-1:0] slot_guard = '0, slot_src = '0;
  logic [PC_W-1:0] branch_target = '0;
  logic [NU-1:0] unit_busy = '0;
  logic wr_en = 1'b0;
  logic [RW-1:0] wr_addr = '0;
  logic [XLEN-1:0] wr_data = '0;
  logic [S-1:0] disp_valid, disp_wb_en;
  logic [S*UW-1:0] disp_unit;
  logic [S*XLEN-1:0] disp_operand;
  logic [PC_W-1:0] pc;

  int n_vec = 0, n_bad = 0;
  bit done = 1'b0;
  logic [PC_W-1:0] exp_pc = '0;

  always #4 clk = ~clk;

  vliw_issue_stage i_vliw_issue_stage (
    .clk_i(clk), .rst_ni(rst_ni),
    .word_valid_i(word_valid), .word_ready_o(word_ready),
    .slot_present_i(slot_present), .slot_branch_i(slot_branch), .slot_wb_i(slot_wb),
    .slot_unit_i(slot_unit), .slot_guard_i(slot_guard), .slot_src_i(slot_src),
    .branch_target_i(branch_target), .unit_busy_i(unit_busy),
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .disp_valid_o(disp_valid), .disp_wb_en_o(disp_wb_en), .disp_unit_o(disp_unit),
    .disp_operand_o(disp_operand), .pc_o(pc)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic clear_word();
    word_valid = 1'b0; slot_present = '0; slot_branch = '0; slot_wb = '0;
    slot_unit = '0; slot_guard = '0; slot_src = '0; unit_busy = '0;
  endtask

  task automatic set_slot(input int s, input int g, input int src, input int u,
                          input bit wb, input bit br);
    slot_present[s] = 1'b1;
    slot_guard[s*RW +: RW] = RW'(g);
    slot_src[s*RW +: RW] = RW'(src);
    slot_unit[s*UW +: UW] = UW'(u);
    slot_wb[s] = wb;
    slot_branch[s] = br;
  endtask

  task automatic write_reg(input int a, input logic [XLEN-1:0] d);
    wr_en = 1'b1; wr_addr = RW'(a); wr_data = d;
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic issue();
    word_valid = 1'b1;
    @(posedge clk); @(negedge clk);
    word_valid = 1'b0;
    exp_pc = exp_pc + 1;
  endtask

  task automatic t_reset();
    check("R1 pc after reset", pc, 0);
    check("R1 valid after reset", disp_valid, 0);
    check("R1 wb after reset", disp_wb_en, 0);
    check("R1 ready after reset", word_ready, 1);
  endtask

  task automatic t_guard();
    write_reg(5, 32'h3);
    write_reg(6, 32'h2);
    write_reg(7, 32'hAAAA_0001);
    write_reg(9, 32'h1234_5678);
    clear_word();
    set_slot(0, 5, 9, 2, 1'b1, 1'b0);
    set_slot(1, 6, 9, 3, 1'b1, 1'b0);
    set_slot(2, 7, 7, 4, 1'b0, 1'b0);
    slot_guard[3*RW +: RW] = RW'(5); // not present
    issue();
    check("R2 guard odd/even dispatch", disp_valid, 5'b00101);
    check("R10 wb only for dispatched wb slots", disp_wb_en, 5'b00001);
    check("R11 operand slot0", disp_operand[0 +: XLEN], 32'h1234_5678);
    check("R11 operand slot2", disp_operand[2*XLEN +: XLEN], 32'hAAAA_0001);
    check("R11 unit slot2", disp_unit[2*UW +: UW], 4);
    check("R8 pc after one word", pc, exp_pc);
  endtask

  task automatic t_constant_regs();
    write_reg(0, 32'hFFFF_FFFF);
    write_reg(1, 32'h0);
    clear_word();
    set_slot(0, 0, 5, 1, 1'b1, 1'b0);
    set_slot(1, 1, 5, 1, 1'b1, 1'b0);
    set_slot(2, 1, 0, 1, 1'b0, 1'b0);
    set_slot(3, 1, 1, 1, 1'b0, 1'b0);
    issue();
    check("R3 R4 never/always guards", disp_valid, 5'b01110);
    check("R3 reg0 operand after write", disp_operand[2*XLEN +: XLEN], 0);
    check("R4 reg1 operand after write", disp_operand[3*XLEN +: XLEN], 1);
    check("R10 wb slot1 only", disp_wb_en, 5'b00010);
  endtask

  task automatic t_stall();
    logic [PC_W-1:0] held;
    clear_word();
    set_slot(0, 1, 9, 4, 1'b1, 1'b0);
    unit_busy[4] = 1'b1;
    #1;
    check("R5 ready low when unit busy", word_ready, 0);
    held = pc;
    word_valid = 1'b1;
    for (int i = 0; i < 3; i++) begin
      @(posedge clk); @(negedge clk);
      check("R5 no dispatch while stalled", disp_valid, 0);
      check("R5 pc held while stalled", pc, held);
    end
    unit_busy[4] = 1'b0;
    #1;
    check("R5 ready once unit frees", word_ready, 1);
    @(posedge clk); @(negedge clk);
    word_valid = 1'b0;
    exp_pc = exp_pc + 1;
    check("R5 issues after release", disp_valid, 5'b00001);
    check("R8 pc after stalled word", pc, exp_pc);
  endtask

  task automatic t_squash_no_stall();
    clear_word();
    set_slot(0, 0, 9, 4, 1'b1, 1'b0);
    set_slot(1, 6, 9, 5, 1'b1, 1'b0);
    set_slot(2, 1, 9, 2, 1'b1, 1'b0);
    unit_busy[4] = 1'b1;
    unit_busy[5] = 1'b1;
    #1;
    check("R6 squashed slots do not stall", word_ready, 1);
    issue();
    check("R6 only live slot dispatched", disp_valid, 5'b00100);
  endtask

  task automatic t_no_compat();
    clear_word();
    set_slot(0, 1, 9, 3, 1'b1, 1'b0);
    set_slot(1, 5, 5, 3, 1'b1, 1'b0);
    issue();
    check("R7 same-unit slots both dispatch", disp_valid, 5'b00011);
    check("R7 slot0 unit", disp_unit[0 +: UW], 3);
    check("R7 slot1 unit", disp_unit[UW +: UW], 3);
  endtask

  task automatic t_idle();
    clear_word();
    set_slot(0, 1, 9, 1, 1'b1, 1'b0);
    repeat (2) begin
      @(posedge clk); @(negedge clk);
      check("R8 pc stable when idle", pc, exp_pc);
      check("R8 no dispatch when idle", disp_valid, 0);
    end
  endtask

  task automatic t_branch();
    clear_word();
    set_slot(0, 1, 9, 1, 1'b0, 1'b1);
    branch_target = 32'h100;
    issue();
    check("R9 pc after branch word", pc, exp_pc);
    branch_target = 32'h7777;
    for (int k = 1; k <= 3; k++) begin
      clear_word();
      set_slot(0, 1, 9, 1, 1'b1, 1'b0);
      if (k == 2) begin
        unit_busy[1] = 1'b1;
        word_valid = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        check("R9 stall inside window holds pc", pc, exp_pc);
        unit_busy[1] = 1'b0;
        word_valid = 1'b0;
      end
      issue();
      check("R9 delay word executes", disp_valid, 5'b00001);
      if (k < 3) check("R9 pc inside window", pc, exp_pc);
      else begin
        exp_pc = 32'h100;
        check("R9 pc loads target after third word", pc, exp_pc);
      end
    end
    clear_word();
    set_slot(0, 1, 9, 1, 1'b1, 1'b0);
    issue();
    check("R9 pc continues from target", pc, exp_pc);
  endtask

  task automatic t_squashed_branch();
    clear_word();
    set_slot(0, 0, 9, 1, 1'b0, 1'b1);
    set_slot(1, 6, 9, 1, 1'b0, 1'b1);
    branch_target = 32'h300;
    issue();
    for (int k = 0; k < 4; k++) begin
      clear_word();
      set_slot(0, 1, 9, 1, 1'b0, 1'b0);
      issue();
    end
    check("R9 squashed branch ignored", pc, exp_pc);
  endtask

  task automatic t_write_then_use();
    clear_word();
    set_slot(0, 20, 20, 2, 1'b1, 1'b0);
    issue();
    check("R11 reset reg reads zero as guard", disp_valid, 0);
    write_reg(20, 32'h8000_0001);
    issue();
    check("R11 written guard takes effect", disp_valid, 5'b00001);
    check("R11 written operand visible", disp_operand[0 +: XLEN], 32'h8000_0001);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 pc held in reset", pc, 0);
    rst_ni = 1'b1;
    @(posedge clk); @(negedge clk);
    t_reset();
    t_guard();
    t_constant_regs();
    t_stall();
    t_squash_no_stall();
    t_no_compat();
    t_idle();
    t_branch();
    t_squashed_branch();
    t_write_then_use();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_vec++;
      n_bad++;
      $display("FAIL all: watchdog act=running exp=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule